// File: doc/BRIEF.md
# Performance Alert Event-Based Branch Controller

This block converts an alert pulse from the performance counters into a branch to a user-level handler. It holds four registers, all loaded through one write port: a monitor control register, a branch status register, a return-address register and a handler-address register.

An alert pulse is accepted only when the control register allows branches on alerts. An accepted alert rewrites the freeze and alert bits in the control register and sets one pending flag. While the core reports problem (user) state, the pending flag is consumed. If the status register has both its global enable and its monitor enable set, the branch is taken. Taking the branch clears the global enable, records the occurrence, saves the next-instruction address as the return address, and sends a one-cycle redirect strobe carrying the handler address.

The write port is a plain strobe that is always accepted. The redirect output is a strobe with no ready input. The core's fetch unit must act on it in the cycle it appears, because the block applies no back-pressure and holds no second redirect.

Top module: `ebb_alert_branch`

## Requirements
- R1: When the branch-enable bit (control bit 4) is 0, an alert pulse changes no register, no pending flag and no output.
- R2: On an accepted alert with the freeze-on-condition bit (control bit 1) set, that bit is cleared and the freeze bit (control bit 0) is set, from the next cycle.
- R3: On an accepted alert with the alert-enable bit (control bit 2) set, that bit is cleared and the alert-seen bit (control bit 3) is set, from the next cycle.
- R4: An accepted alert sets the pending flag in the next cycle. The flag stays set until it is consumed.
- R5: The pending flag is consumed only in a cycle where it is set and the problem-state input is 1. While problem state is 0, the flag stays set.
- R6: A consumed flag clears in the next cycle. The branch is taken only if status bit 0 (global enable) and status bit 1 (monitor enable) are both 1. Otherwise the status, return address and redirect are left unchanged.
- R7: A taken branch clears status bit 0 and sets status bit 2 (monitor event seen). Every other status bit is kept.
- R8: A taken branch loads the return-address register with the instruction address present in the consume cycle. The redirect address is the handler register value in that cycle.
- R9: The redirect valid output is 1 for exactly the one cycle after each taken branch, and 0 otherwise.
- R10: An alert that arrives while the flag is pending, or in the cycle the flag is consumed, causes no second delivery.
- R11: The write port selects a register with wr_sel_i: 0 control, 1 status, 2 return address, 3 handler address. A write is dropped when a hardware update changes the same register in that cycle (an accepted alert for control; a taken branch for status and return address).
- R12: After reset, all four registers, the pending flag and the redirect outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alert_i | input | 1 | Alert pulse from the counter logic |
| prob_st_i | input | 1 | Core is in problem (user) state |
| pc_i | input | ADDR_W | Current next-instruction address |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | ADDR_W | Write data |
| ctl_o | output | CTL_W | Monitor control register |
| sts_o | output | STS_W | Branch status register |
| ret_o | output | ADDR_W | Return-address register |
| hdl_o | output | ADDR_W | Handler-address register |
| pend_o | output | 1 | Pending interrupt flag |
| redir_vld_o | output | 1 | One-cycle redirect strobe |
| redir_addr_o | output | ADDR_W | Redirect target, valid with the strobe |

## Verification
Two events can fall in the same cycle. A software write and a hardware update can both target one register: a control write in the same cycle as an accepted alert, or a status or return-address write in the same cycle as a taken branch. The directed cases provoke both pairings deliberately, and the random phase produces them many more times by biasing writes and alerts to overlap. The result is judged against a bench model in which the hardware update wins. A second collision is also provoked: an alert landing in the cycle the pending flag is consumed. The check there is that exactly one redirect strobe follows.

// File: rtl/ebb_pkg.sv
package ebb_pkg;
  // control register bit positions
  localparam int CB_FRZ      = 0;
  localparam int CB_FRZ_COND = 1;
  localparam int CB_ALR_EN   = 2;
  localparam int CB_ALR_SEEN = 3;
  localparam int CB_BR_EN    = 4;
  // status register bit positions
  localparam int SB_GLB_EN   = 0;
  localparam int SB_MON_EN   = 1;
  localparam int SB_MON_SEEN = 2;

  typedef enum logic [1:0] {
    SEL_CTL = 2'd0,
    SEL_STS = 2'd1,
    SEL_RET = 2'd2,
    SEL_HDL = 2'd3
  } wsel_e;
endpackage

// File: rtl/ebb_alert_unit.sv
module ebb_alert_unit
  import ebb_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alert_i,
  input  logic             wr_ctl_i,
  input  logic [CTL_W-1:0] wr_data_i,
  input  logic             consume_i,
  output logic [CTL_W-1:0] ctl_q,
  output logic             pend_q
);
  logic             accept;
  logic [CTL_W-1:0] ctl_upd;
  logic [CTL_W-1:0] ctl_n;
  logic             pend_n;

  assign accept = alert_i & ctl_q[CB_BR_EN];

  always_comb begin
    ctl_upd = ctl_q;
    if (ctl_q[CB_FRZ_COND]) begin
      ctl_upd[CB_FRZ_COND] = 1'b0;
      ctl_upd[CB_FRZ]      = 1'b1;
    end
    if (ctl_q[CB_ALR_EN]) begin
      ctl_upd[CB_ALR_EN]   = 1'b0;
      ctl_upd[CB_ALR_SEEN] = 1'b1;
    end
  end

  always_comb begin
    if (accept)        ctl_n = ctl_upd;
    else if (wr_ctl_i) ctl_n = wr_data_i;
    else               ctl_n = ctl_q;
    // a consume clears; an alert in the same cycle is absorbed
    if (consume_i)     pend_n = 1'b0;
    else               pend_n = pend_q | accept;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_n;
      pend_q <= pend_n;
    end
  end

  assert_ignored_alert_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_i && !ctl_q[CB_BR_EN] && !wr_ctl_i && !consume_i) |=> ($stable(ctl_q) && $stable(pend_q)));
  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_i && ctl_q[CB_BR_EN] && ctl_q[CB_FRZ_COND]) |=> (ctl_q[CB_FRZ] && !ctl_q[CB_FRZ_COND]));
  assert_alert_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_i && ctl_q[CB_BR_EN] && ctl_q[CB_ALR_EN]) |=> (ctl_q[CB_ALR_SEEN] && !ctl_q[CB_ALR_EN]));
  assert_pend_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_i && ctl_q[CB_BR_EN] && !consume_i) |=> pend_q);
  assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !consume_i) |=> pend_q);
  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    consume_i |=> !pend_q);
endmodule

// File: rtl/ebb_branch_unit.sv
module ebb_branch_unit
  import ebb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_i,
  input  logic              prob_st_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] hdl_i,
  input  logic              wr_sts_i,
  input  logic              wr_ret_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic              consume_o,
  output logic [STS_W-1:0]  sts_q,
  output logic [ADDR_W-1:0] ret_q,
  output logic              redir_vld_q,
  output logic [ADDR_W-1:0] redir_addr_q
);
  logic              take;
  logic [STS_W-1:0]  sts_n;
  logic [ADDR_W-1:0] ret_n;

  assign consume_o = pend_i & prob_st_i;
  assign take      = consume_o & sts_q[SB_GLB_EN] & sts_q[SB_MON_EN];

  always_comb begin
    sts_n = sts_q;
    ret_n = ret_q;
    if (take) begin
      sts_n[SB_GLB_EN]   = 1'b0;
      sts_n[SB_MON_SEEN] = 1'b1;
      ret_n              = pc_i;
    end else begin
      if (wr_sts_i) sts_n = wr_data_i[STS_W-1:0];
      if (wr_ret_i) ret_n = wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q        <= '0;
      ret_q        <= '0;
      redir_vld_q  <= 1'b0;
      redir_addr_q <= '0;
    end else begin
      sts_q       <= sts_n;
      ret_q       <= ret_n;
      redir_vld_q <= take;
      if (take) redir_addr_q <= hdl_i;
    end
  end

  assert_user_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !prob_st_i |=> !redir_vld_q);
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_o && !(sts_q[SB_GLB_EN] && sts_q[SB_MON_EN])) |=> !redir_vld_q);
  assert_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_q |-> (!sts_q[SB_GLB_EN] && sts_q[SB_MON_SEEN]));
  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_q |-> (ret_q == $past(pc_i) && redir_addr_q == $past(hdl_i)));
  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_q |=> !redir_vld_q);
  assert_from_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redir_vld_q) |-> $past(pend_i));
endmodule

// File: rtl/ebb_alert_branch.sv
module ebb_alert_branch
  import ebb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CTL_W  = 8,
  parameter int STS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alert_i,
  input  logic              prob_st_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [STS_W-1:0]  sts_o,
  output logic [ADDR_W-1:0] ret_o,
  output logic [ADDR_W-1:0] hdl_o,
  output logic              pend_o,
  output logic              redir_vld_o,
  output logic [ADDR_W-1:0] redir_addr_o
);
  wsel_e             sel;
  logic              wr_ctl, wr_sts, wr_ret, wr_hdl;
  logic              consume;
  logic [ADDR_W-1:0] hdl_q;

  assign sel    = wsel_e'(wr_sel_i);
  assign wr_ctl = wr_en_i && (sel == SEL_CTL);
  assign wr_sts = wr_en_i && (sel == SEL_STS);
  assign wr_ret = wr_en_i && (sel == SEL_RET);
  assign wr_hdl = wr_en_i && (sel == SEL_HDL);

  always_ff @(posedge clk) begin
    if (!rst_n)      hdl_q <= '0;
    else if (wr_hdl) hdl_q <= wr_data_i;
  end

  ebb_alert_unit #(.CTL_W(CTL_W)) u_alert (
    .clk       (clk),
    .rst_n     (rst_n),
    .alert_i   (alert_i),
    .wr_ctl_i  (wr_ctl),
    .wr_data_i (wr_data_i[CTL_W-1:0]),
    .consume_i (consume),
    .ctl_q     (ctl_o),
    .pend_q    (pend_o)
  );

  ebb_branch_unit #(.ADDR_W(ADDR_W), .STS_W(STS_W)) u_branch (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_i       (pend_o),
    .prob_st_i    (prob_st_i),
    .pc_i         (pc_i),
    .hdl_i        (hdl_q),
    .wr_sts_i     (wr_sts),
    .wr_ret_i     (wr_ret),
    .wr_data_i    (wr_data_i),
    .consume_o    (consume),
    .sts_q        (sts_o),
    .ret_q        (ret_o),
    .redir_vld_q  (redir_vld_o),
    .redir_addr_q (redir_addr_o)
  );

  assign hdl_o = hdl_q;

  assert_hdl_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hdl |=> (hdl_o == $past(wr_data_i)));
endmodule

// File: tb/ebb_alert_branch_bench.sv
`timescale 1ns/1ps
module ebb_alert_branch_bench;
  localparam int AW = 32;
  localparam int CW = 8;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alert_i = 1'b0, prob_st_i = 1'b0, wr_en_i = 1'b0;
  logic [AW-1:0] pc_i = '0, wr_data_i = '0;
  logic [1:0]    wr_sel_i = '0;
  logic [CW-1:0] ctl_o;
  logic [SW-1:0] sts_o;
  logic [AW-1:0] ret_o, hdl_o, redir_addr_o;
  logic          pend_o, redir_vld_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [CW-1:0] m_ctl;
  logic [SW-1:0] m_sts;
  logic [AW-1:0] m_ret, m_hdl, m_raddr;
  logic          m_pend, m_rvld;

  always #2.5 clk = ~clk;

  ebb_alert_branch u_ebb_alert_branch (
    .clk(clk), .rst_n(rst_n), .alert_i(alert_i), .prob_st_i(prob_st_i),
    .pc_i(pc_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .ctl_o(ctl_o), .sts_o(sts_o), .ret_o(ret_o), .hdl_o(hdl_o), .pend_o(pend_o),
    .redir_vld_o(redir_vld_o), .redir_addr_o(redir_addr_o)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // control register after an accepted alert (R2, R3)
  function automatic logic [CW-1:0] ctl_alert(input logic [CW-1:0] c);
    logic [CW-1:0] r = c;
    if (c[1]) begin r[1] = 1'b0; r[0] = 1'b1; end
    if (c[2]) begin r[2] = 1'b0; r[3] = 1'b1; end
    return r;
  endfunction

  task automatic step(input logic a, input logic ps, input logic [AW-1:0] pc,
                      input logic we, input logic [1:0] sel, input logic [AW-1:0] wd);
    logic acc, cons, take;
    logic [CW-1:0] e_ctl; logic [SW-1:0] e_sts; logic [AW-1:0] e_ret, e_hdl;
    logic e_pend;
    @(negedge clk);
    alert_i = a; prob_st_i = ps; pc_i = pc; wr_en_i = we; wr_sel_i = sel; wr_data_i = wd;
    acc  = a & m_ctl[4];
    cons = m_pend & ps;
    take = cons & m_sts[0] & m_sts[1];
    e_ctl = acc ? ctl_alert(m_ctl) : ((we && sel == 2'd0) ? wd[CW-1:0] : m_ctl);
    e_pend = cons ? 1'b0 : (m_pend | acc);
    if (take) begin
      e_sts = m_sts; e_sts[0] = 1'b0; e_sts[2] = 1'b1; e_ret = pc;
    end else begin
      e_sts = (we && sel == 2'd1) ? wd[SW-1:0] : m_sts;
      e_ret = (we && sel == 2'd2) ? wd : m_ret;
    end
    e_hdl = (we && sel == 2'd3) ? wd : m_hdl;
    if (take) m_raddr = m_hdl;
    m_rvld = take;
    m_ctl = e_ctl; m_sts = e_sts; m_ret = e_ret; m_hdl = e_hdl; m_pend = e_pend;
    @(posedge clk); #1;
    check("R1 R2 R3 control", AW'(ctl_o), AW'(m_ctl));
    check("R4 R5 R10 pending", AW'(pend_o), AW'(m_pend));
    check("R6 R7 status", AW'(sts_o), AW'(m_sts));
    check("R8 R11 return", ret_o, m_ret);
    check("R11 handler", hdl_o, m_hdl);
    check("R9 redirect valid", AW'(redir_vld_o), AW'(m_rvld));
    if (m_rvld) check("R8 redirect addr", redir_addr_o, m_raddr);
  endtask

  task automatic idle(input logic ps);
    step(1'b0, ps, 32'h0, 1'b0, 2'd0, 32'h0);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    step(1'b0, 1'b0, 32'h0, 1'b1, sel, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int red_cnt;
    void'($urandom(32'h5eed_0042));
    m_ctl = '0; m_sts = '0; m_ret = '0; m_hdl = '0; m_pend = 1'b0; m_rvld = 1'b0; m_raddr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R12: reset values
    check("R12 control reset", AW'(ctl_o), '0);
    check("R12 status reset", AW'(sts_o), '0);
    check("R12 return reset", ret_o, '0);
    check("R12 handler reset", hdl_o, '0);
    check("R12 pending reset", AW'(pend_o), '0);
    check("R12 redirect reset", AW'(redir_vld_o), '0);

    // R1: alert ignored without branch enable
    wr(2'd0, 32'h06);
    step(1'b1, 1'b1, 32'h44, 1'b0, 2'd0, 0);
    check("R1 control untouched", AW'(ctl_o), 32'h06);
    check("R1 no pending", AW'(pend_o), 0);

    // R2 R3 R4: accepted alert rewrites control
    wr(2'd0, 32'h16);
    step(1'b1, 1'b0, 32'h0, 1'b0, 2'd0, 0);
    check("R2 R3 control rewrite", AW'(ctl_o), 32'h19);
    check("R4 pending set", AW'(pend_o), 1);

    // R5: stays pending outside problem state
    wr(2'd1, 32'h03);
    wr(2'd3, 32'h0000_1000);
    idle(1'b0); idle(1'b0);
    check("R5 held while privileged", AW'(pend_o), 1);

    // R6 R7 R8 R9: delivery, with a status write colliding (R11)
    step(1'b0, 1'b1, 32'h0000_0200, 1'b1, 2'd1, 32'h0);
    check("R9 strobe", AW'(redir_vld_o), 1);
    check("R8 target", redir_addr_o, 32'h0000_1000);
    check("R8 return saved", ret_o, 32'h0000_0200);
    check("R7 R11 status after branch", AW'(sts_o), 32'h06);
    idle(1'b1);
    check("R9 one cycle", AW'(redir_vld_o), 0);

    // R10: alerts while pending and at consume give one delivery
    wr(2'd1, 32'h03);
    wr(2'd0, 32'h10);
    step(1'b1, 1'b0, 0, 1'b0, 2'd0, 0);
    step(1'b1, 1'b0, 0, 1'b0, 2'd0, 0);
    red_cnt = 0;
    step(1'b1, 1'b1, 32'h300, 1'b0, 2'd0, 0);
    red_cnt += int'(redir_vld_o);
    repeat (3) begin idle(1'b1); red_cnt += int'(redir_vld_o); end
    check("R10 single delivery", red_cnt, 1);

    // R11: control write loses to accepted alert
    wr(2'd0, 32'h14);
    step(1'b1, 1'b0, 0, 1'b1, 2'd0, 32'h00);
    check("R11 alert beats write", AW'(ctl_o), 32'h18);

    // R6: gate closed, pending cleared, no branch
    wr(2'd1, 32'h02);
    step(1'b0, 1'b1, 32'h77, 1'b0, 2'd0, 0);
    check("R6 no branch", AW'(redir_vld_o), 0);
    check("R6 pending cleared", AW'(pend_o), 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] sel;
      logic [AW-1:0] wd;
      sel = 2'($urandom);
      wd  = $urandom;
      if (sel == 2'd0 && ($urandom % 4) != 0) wd[4] = 1'b1;
      if (sel == 2'd1 && ($urandom % 3) != 0) wd[1:0] = 2'b11;
      step(($urandom % 3) == 0, ($urandom % 2) == 0, $urandom,
           ($urandom % 4) == 0, sel, wd);
    end
    finish_run();
  end
endmodule